// File: doc/BRIEF.md
# Programmable-Range Saturation Unit

This block forces a 32-bit two's-complement operand into a range set by a bit count N. In signed mode it keeps a value that fits in N+1 signed bits and otherwise replaces it with the nearest end of that range. In unsigned mode the range runs from zero to 2^N-1. A dual-halfword mode splits the operand into two 16-bit signed lanes. Each lane is limited on its own using the same N, and the two 16-bit results are packed back into their halves.

A sticky flag records that some operation had to clamp. Once it is set, it stays set until an explicit clear input drops it. A datapath issues one operation per cycle with a valid strobe. The result and the flag update on the following clock edge. The operand is taken as it arrives; any pre-shift happens upstream.

Top module: `sat_clamp_unit`

## Requirements
- R1: With `is_unsigned`=0 and `dual_lane`=0, the operand is shifted arithmetically right by N. If that value is greater than 0, the result is 2^N-1. If it is less than -1, the result is -2^N. Otherwise the operand is passed through unchanged.
- R2: With `is_unsigned`=1 and `dual_lane`=0, a negative operand gives 0. An operand greater than 2^N-1 gives 2^N-1. Any other operand is passed through unchanged.
- R3: Every clamp replaces a value in either mode. When an accepted operation has a replaced value or lane, `q_flag` reads 1 one cycle later.
- R4: With `dual_lane`=1, the low lane (bits 15:0) is the operand's low half sign-extended from 16 bits. The high lane (bits 31:16) is the operand shifted arithmetically right by 16. Each lane is saturated by the R1/R2 rule for the selected mode with the same N, and each result is truncated to 16 bits and placed in its own half.
- R5: In dual-halfword mode a `sat_bits` value from 16 to 31 behaves exactly as 15. In single mode all values from 0 to 31 are used as given.
- R6: An accepted operation that clamps nothing leaves `q_flag` unchanged.
- R7: `q_clear`=1 makes `q_flag` read 0 on the next cycle. The exception is an accepted operation in the same cycle that clamps: then `q_flag` reads 1.
- R8: `result` reflects an operation one cycle after `in_valid`=1. While `in_valid`=0, `result` holds its value, whatever the other inputs do.
- R9: During reset `result` is 0 and `q_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept the operation this cycle |
| operand | input | 32 | Two's-complement value to limit |
| sat_bits | input | 5 | Bit count N that sets the range |
| is_unsigned | input | 1 | 1: unsigned range, 0: signed range |
| dual_lane | input | 1 | 1: two independent 16-bit lanes |
| q_clear | input | 1 | Clear the sticky saturation flag |
| result | output | 32 | Limited value, registered |
| q_flag | output | 1 | Sticky saturation indicator |

## Verification
Both the limited value and the flag are due exactly one rising edge after the cycle in which `in_valid` is high. Only one register lies between the inputs and either output. The bench drives each operation on a falling edge and holds it for one full cycle. It drops the strobe at the next falling edge and compares both outputs right there. Hold and clear behaviour are checked the same way. The inputs are changed with the strobe low, and the outputs are compared one cycle later.

// File: rtl/sat_pkg.sv
package sat_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;
  localparam int SH_W   = $clog2(WORD_W);

  typedef struct packed {
    logic              hit;
    logic [WORD_W-1:0] val;
  } sat_res_t;

  // Limit a word to N+1 signed bits or to [0, 2^N-1].
  function automatic sat_res_t sat_word(input logic [WORD_W-1:0] v,
                                        input logic [SH_W-1:0]   n,
                                        input logic              uns);
    sat_res_t          r;
    logic [WORD_W-1:0] lim;
    logic [WORD_W-1:0] top;
    lim   = (WORD_W'(1) << n) - WORD_W'(1);
    top   = WORD_W'($signed(v) >>> n);
    r.hit = 1'b0;
    r.val = v;
    if (uns) begin
      if (v[WORD_W-1]) begin
        r.hit = 1'b1;
        r.val = '0;
      end else if (v > lim) begin
        r.hit = 1'b1;
        r.val = lim;
      end
    end else begin
      if ($signed(top) > 0) begin
        r.hit = 1'b1;
        r.val = lim;
      end else if ($signed(top) < -1) begin
        r.hit = 1'b1;
        r.val = ~lim;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/sat_nlimit.sv
module sat_nlimit #(
  parameter int HALF_W = sat_pkg::HALF_W,
  parameter int SH_W   = sat_pkg::SH_W
) (
  input  logic [SH_W-1:0] n_req,
  input  logic            dual,
  output logic [SH_W-1:0] n_eff
);
  localparam logic [SH_W-1:0] HALF_MAX = SH_W'(HALF_W - 1);

  always_comb begin
    n_eff = n_req;
    if (dual && (n_req > HALF_MAX)) n_eff = HALF_MAX;
  end
endmodule

// File: rtl/sat_lane.sv
module sat_lane #(
  parameter int LANE_W = sat_pkg::HALF_W,
  parameter int WORD_W = sat_pkg::WORD_W,
  parameter int SH_W   = sat_pkg::SH_W
) (
  input  logic [LANE_W-1:0] lane_in,
  input  logic [SH_W-1:0]   n,
  input  logic              uns,
  output logic [LANE_W-1:0] lane_out,
  output logic              lane_hit
);
  import sat_pkg::*;

  logic [WORD_W-1:0] wide_in;
  sat_res_t          r;

  generate
    if (LANE_W < WORD_W) begin : g_ext
      logic unused_hi;
      assign wide_in   = {{(WORD_W-LANE_W){lane_in[LANE_W-1]}}, lane_in};
      assign unused_hi = ^r.val[WORD_W-1:LANE_W];
    end else begin : g_full
      assign wide_in = lane_in;
    end
  endgenerate

  assign r        = sat_word(wide_in, n, uns);
  assign lane_out = r.val[LANE_W-1:0];
  assign lane_hit = r.hit;
endmodule

// File: rtl/sat_clamp_unit.sv
module sat_clamp_unit #(
  parameter int WORD_W = sat_pkg::WORD_W,
  parameter int HALF_W = sat_pkg::HALF_W,
  parameter int SH_W   = sat_pkg::SH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] operand,
  input  logic [SH_W-1:0]   sat_bits,
  input  logic              is_unsigned,
  input  logic              dual_lane,
  input  logic              q_clear,
  output logic [WORD_W-1:0] result,
  output logic              q_flag
);
  localparam int NUM_HALF = WORD_W / HALF_W;

  logic [SH_W-1:0]                 n_eff;
  logic [WORD_W-1:0]               word_out;
  logic                            word_hit;
  logic [NUM_HALF-1:0][HALF_W-1:0] half_out;
  logic [NUM_HALF-1:0]             half_hit;
  logic                            any_hit;
  logic [WORD_W-1:0]               result_d;
  logic                            sat_event;

  sat_nlimit #(.HALF_W(HALF_W), .SH_W(SH_W)) u_nlim (
    .n_req (sat_bits),
    .dual  (dual_lane),
    .n_eff (n_eff)
  );

  sat_lane #(.LANE_W(WORD_W), .WORD_W(WORD_W), .SH_W(SH_W)) u_word (
    .lane_in  (operand),
    .n        (n_eff),
    .uns      (is_unsigned),
    .lane_out (word_out),
    .lane_hit (word_hit)
  );

  for (genvar g = 0; g < NUM_HALF; g++) begin : g_half
    sat_lane #(.LANE_W(HALF_W), .WORD_W(WORD_W), .SH_W(SH_W)) u_half (
      .lane_in  (operand[g*HALF_W +: HALF_W]),
      .n        (n_eff),
      .uns      (is_unsigned),
      .lane_out (half_out[g]),
      .lane_hit (half_hit[g])
    );
  end

  assign any_hit   = dual_lane ? (|half_hit) : word_hit;
  assign result_d  = dual_lane ? half_out : word_out;
  assign sat_event = in_valid && any_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      q_flag <= 1'b0;
    end else begin
      if (in_valid) result <= result_d;
      q_flag <= (q_flag && !q_clear) || sat_event;
    end
  end

  AST_HIT_SETS_Q: assert property (@(posedge clk) disable iff (!rst_n)
    sat_event |=> q_flag); // R3
  AST_Q_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (q_flag && !q_clear) |=> q_flag); // R6
  AST_Q_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (q_clear && !sat_event) |=> !q_flag); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result)); // R8
  AST_UNS_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_unsigned && !dual_lane) |=> !result[WORD_W-1]); // R2
  AST_DUAL_NLIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    dual_lane |-> (n_eff < SH_W'(HALF_W))); // R5
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (result == '0 && !q_flag)); // R9
endmodule

// File: tb/tb_sat_clamp_unit.sv
module tb_sat_clamp_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] operand = '0;
  logic [4:0]  sat_bits = '0;
  logic        is_unsigned = 1'b0;
  logic        dual_lane = 1'b0;
  logic        q_clear = 1'b0;
  logic [31:0] result;
  logic        q_flag;

  int vectors = 0;
  int miscompares = 0;
  bit model_q = 1'b0;
  logic [31:0] model_res = '0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sat_clamp_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
    .sat_bits(sat_bits), .is_unsigned(is_unsigned), .dual_lane(dual_lane),
    .q_clear(q_clear), .result(result), .q_flag(q_flag)
  );

  // Returns {hit, value} using wide integer range bounds.
  function automatic logic [32:0] ref_clamp(longint v, int n, bit uns);
    longint lo, hi;
    if (uns) begin lo = 0; hi = (64'sd1 <<< n) - 1; end
    else begin lo = -(64'sd1 <<< n); hi = (64'sd1 <<< n) - 1; end
    if (v < lo) return {1'b1, 32'(lo)};
    if (v > hi) return {1'b1, 32'(hi)};
    return {1'b0, 32'(v)};
  endfunction

  function automatic logic [32:0] ref_op(logic [31:0] op, int n, bit uns, bit dual);
    logic [32:0] a, b;
    if (!dual) return ref_clamp(longint'($signed(op)), n, uns);
    if (n > 15) n = 15;
    a = ref_clamp(longint'($signed(op[15:0])), n, uns);
    b = ref_clamp(longint'($signed(op[31:16])), n, uns);
    return {a[32] | b[32], b[15:0], a[15:0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(string req, logic [31:0] op, int n, bit uns, bit dual, bit clr);
    logic [32:0] e;
    e = ref_op(op, n, uns, dual);
    operand = op; sat_bits = 5'(n); is_unsigned = uns; dual_lane = dual;
    q_clear = clr; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; q_clear = 1'b0;
    model_res = e[31:0];
    model_q = (model_q && !clr) || e[32];
    check(req, result, model_res);
    check({req, " q"}, 32'(q_flag), 32'(model_q));
  endtask

  task automatic clear_only();
    q_clear = 1'b1;
    @(negedge clk);
    q_clear = 1'b0;
    model_q = 1'b0;
    check("R7 clear", 32'(q_flag), 32'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5A7C));
    @(negedge clk); @(negedge clk);
    check("R9 reset result", result, 32'd0);
    check("R9 reset q", 32'(q_flag), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op("R1 pass", 32'd100, 7, 0, 0, 0);
    run_op("R6 no change", 32'hFFFF_FF80, 7, 0, 0, 0);
    run_op("R1 high", 32'd200, 7, 0, 0, 0);
    run_op("R6 sticky", 32'd5, 7, 0, 0, 0);
    run_op("R1 low", -32'sd200, 7, 0, 0, 0);
    run_op("R1 n0", 32'd1, 0, 0, 0, 0);
    run_op("R1 n31", 32'h8000_0000, 31, 0, 0, 0);
    clear_only();
    run_op("R2 neg", -32'sd5, 8, 1, 0, 0);
    clear_only();
    run_op("R2 pass", 32'd255, 8, 1, 0, 0);
    run_op("R2 high", 32'd300, 8, 1, 0, 0);
    run_op("R2 n0", 32'd1, 0, 1, 0, 0);
    run_op("R2 n31", 32'h7FFF_FFFF, 31, 1, 0, 0);
    run_op("R7 clear loses to hit", 32'd300, 8, 1, 0, 1);
    check("R7 same cycle", 32'(q_flag), 32'd1);
    run_op("R7 clear with pass", 32'd3, 8, 1, 0, 1);
    check("R7 cleared", 32'(q_flag), 32'd0);
    run_op("R4 signed lanes", {16'hFED4, 16'h012C}, 7, 0, 1, 0);
    clear_only();
    run_op("R5 dual n cap signed", {16'h8000, 16'h7FFF}, 20, 0, 1, 0);
    check("R5 no hit", 32'(q_flag), 32'd0);
    run_op("R5 dual n cap uns", {16'hFED4, 16'h012C}, 31, 1, 1, 0);
    run_op("R4 uns lanes", {16'h0100, 16'h0020}, 4, 1, 1, 0);

    // R8: inputs change with strobe low, result must hold
    operand = 32'h1234_5678; sat_bits = 5'd3; is_unsigned = 1'b0; dual_lane = 1'b1;
    @(negedge clk);
    check("R8 hold", result, model_res);
    @(negedge clk);
    check("R8 hold 2", result, model_res);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] op;
      int n;
      bit uns, dual, clr;
      op   = $urandom;
      op   = 32'($signed(op) >>> ($urandom % 32));
      n    = $urandom % 32;
      uns  = 1'($urandom);
      dual = 1'($urandom);
      clr  = (($urandom % 8) == 0);
      run_op(dual ? "R4 random" : (uns ? "R2 random" : "R1 random"), op, n, uns, dual, clr);
    end
    finish_run();
  end
endmodule